// File: doc/BRIEF.md
# Translation Access and Fault Checker

This block sits between a load/store or fetch pipeline and a translation lookaside buffer. Each request arrives as a one-cycle pulse carrying the virtual address, the access size, a fetch/data flag, a write flag and a packed control word that holds the current privilege, MMU-enable, partition, trap-level and context state. In the same cycle the block decides whether the access bypasses translation, needs a real (partition-scoped) lookup or a virtual (context-scoped) lookup, and drives the lookup key to an external TLB. That TLB answers combinationally with a hit flag, a physical page number and four page attributes.

One cycle after the pulse the block presents the physical address, an uncacheable flag and a 3-bit fault code. Faults come from a fixed priority chain: alignment, address range, miss, then the page attribute checks. Every fault is recorded in a fault status register. Data faults also record the (masked) faulting address. Misses load a tag-access register with the missing page and context so that refill software can find them.

Control is a two-state machine. S_IDLE waits for a request. The accept transition (request pulse in S_IDLE) moves to S_RESP. S_RESP holds the response valid for one cycle. From S_RESP the drain transition (no request) returns to S_IDLE, and the chain transition (a new pulse) stays in S_RESP so that back-to-back requests each get a response.

Top module: `xlat_access_checker`

## Requirements
- R1: After reset, rsp_valid is 0 and the fault status, fault address and tag-access registers are all zero.
- R2: A request pulse produces rsp_valid high in exactly the next cycle. rsp_valid stays low in a cycle after one with no request. Fault codes are 0 none, 1 misaligned, 2 address out of range, 3 virtual miss, 4 write protection, 5 no-fault page, 6 privilege violation, 7 real-lookup miss.
- R3: Control word fields: bit 0 hyperprivileged, bit 1 red state, bit 2 privileged, bit 3 32-bit address mask, bit 4 fetch MMU enable, bit 5 data MMU enable, bits 15:8 partition, bits 18:16 trap level, bits 44:32 primary context. A fetch with bit 0 or bit 1 set, or a data access with bit 0 set, bypasses translation. No lookup is issued, the fault is 0, and the physical address is the raw virtual address cut to the physical width.
- R4: Outside bypass, an address with any bit set below the access size (size code 0..3 means 1, 2, 4 or 8 bytes) yields fault 1 and issues no lookup. This check outranks the range check.
- R5: With bit 3 set, address bits 63:32 are cleared before any further use. An address whose bits 63:47 are neither all zero nor all one yields fault 2 and issues no lookup.
- R6: A data access looks up real when the data MMU is off and red state is clear. A fetch looks up real when the fetch MMU is off. Otherwise the lookup is virtual. The lookup key carries the masked page bits, the partition, and the primary context, which is replaced by 0 when the trap level is nonzero.
- R7: A lookup miss yields fault 7 for a real lookup and fault 3 for a virtual one. It loads the tag-access register with masked address bits 63:13 above the 13-bit context.
- R8: On a hit the checks are ordered as follows. A data write to a non-writable page gives fault 4. Otherwise a data access to a no-fault page gives fault 5. Otherwise a non-privileged access (bit 2 clear) to a privileged page gives fault 6. Fetches skip the write and no-fault checks.
- R9: A hit with no fault returns the page number joined to address bits 12:0. Any fault returns physical address 0. The uncacheable flag is set only for a fault-free access to a side-effect page.
- R10: Every fault writes its code into the fault status register. A fault-free response leaves it unchanged.
- R11: A data fault captures the masked address in the fault address register. Fetch faults and fault-free responses leave it unchanged.
- R12: The tag-access register changes only on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request pulse |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write | input | 1 | Data write (ignored for fetches) |
| req_size | input | 2 | log2 of access size in bytes |
| req_va | input | VA_W | Virtual address |
| ctrl_word | input | CTRL_W | Packed privilege / MMU control word |
| lkp_en | output | 1 | Lookup issued to the TLB this cycle |
| lkp_real | output | 1 | Lookup is real (partition-scoped) |
| lkp_page | output | VA_W-PAGE_SH | Virtual page bits of the lookup |
| lkp_ctx | output | CTX_W | Context of the lookup |
| lkp_part | output | PART_W | Partition of the lookup |
| tlb_hit | input | 1 | TLB hit for the current lookup |
| tlb_ppn | input | PA_W-PAGE_SH | Physical page number of the hit entry |
| tlb_writable | input | 1 | Hit page is writable |
| tlb_nofault | input | 1 | Hit page is no-fault only |
| tlb_sidefx | input | 1 | Hit page has side effects |
| tlb_priv | input | 1 | Hit page is privileged |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 3 | Fault code |
| rsp_pa | output | PA_W | Physical address |
| rsp_uncache | output | 1 | Access must be uncacheable |
| fsr_q | output | 3 | Fault status register |
| far_q | output | VA_W | Fault address register |
| tag_q | output | VA_W | Tag-access register |

## Verification
The assertions assume that req_valid is a clean level sampled at the clock edge and that the TLB response pins are stable whenever a lookup is issued, because the block samples them in that same cycle. The bench drives every input on the falling edge and holds the TLB answer for the whole request cycle, the way a combinational TLB would. It keeps req_size inside its four legal codes. The stimulus table covers each bypass mode, each fault in the chain, and pairs of faults that compete for priority. Directed tests add reset, idle cycles and back-to-back requests.

// File: rtl/xac_pkg.sv
package xac_pkg;

    localparam int CTRL_W   = 48;
    localparam int CB_HPRIV = 0;
    localparam int CB_RED   = 1;
    localparam int CB_PRIV  = 2;
    localparam int CB_AMASK = 3;
    localparam int CB_IMMU  = 4;
    localparam int CB_DMMU  = 5;
    localparam int PART_LSB = 8;
    localparam int PART_W   = 8;
    localparam int TL_LSB   = 16;
    localparam int TL_W     = 3;
    localparam int PCTX_LSB = 32;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_ALIGN = 3'd1,
        FLT_RANGE = 3'd2,
        FLT_MISS  = 3'd3,
        FLT_PROT  = 3'd4,
        FLT_NOFLT = 3'd5,
        FLT_PRIV  = 3'd6,
        FLT_RMISS = 3'd7
    } fault_e;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_REAL   = 2'd1,
        MODE_VIRT   = 2'd2
    } xmode_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } state_e;

endpackage

// File: rtl/xac_decode.sv
module xac_decode
    import xac_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int IMPL_VA_W = 48,
    parameter int CTX_W     = 13
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              is_fetch,
    input  logic [1:0]        size,
    input  logic [VA_W-1:0]   va,
    output xmode_e            mode,
    output logic [VA_W-1:0]   va_eff,
    output logic              misalign,
    output logic              out_of_range,
    output logic              user_mode,
    output logic [CTX_W-1:0]  ctx,
    output logic [PART_W-1:0] part
);
    localparam int TOP_W = VA_W - IMPL_VA_W + 1;

    logic hpriv, red, immu_on, dmmu_on, amask;
    logic [3:0] size_mask;
    logic [TOP_W-1:0] top_bits;
    logic unused_ctrl_bits;

    assign hpriv   = ctrl[CB_HPRIV];
    assign red     = ctrl[CB_RED];
    assign amask   = ctrl[CB_AMASK];
    assign immu_on = ctrl[CB_IMMU];
    assign dmmu_on = ctrl[CB_DMMU];
    assign user_mode = ~ctrl[CB_PRIV];
    assign unused_ctrl_bits = ^{ctrl[7:6], ctrl[PCTX_LSB-1:TL_LSB+TL_W],
                                ctrl[CTRL_W-1:PCTX_LSB+CTX_W]};

    // Translation mode selection
    always_comb begin
        if (is_fetch) begin
            if (hpriv || red)      mode = MODE_BYPASS;
            else if (!immu_on)     mode = MODE_REAL;
            else                   mode = MODE_VIRT;
        end else begin
            if (hpriv)                 mode = MODE_BYPASS;
            else if (!dmmu_on && !red) mode = MODE_REAL;
            else                       mode = MODE_VIRT;
        end
    end

    // 32-bit address masking
    generate
        if (VA_W > 32) begin : g_mask
            assign va_eff = amask ? {{(VA_W-32){1'b0}}, va[31:0]} : va;
        end else begin : g_nomask
            assign va_eff = va;
        end
    endgenerate

    assign size_mask    = (4'd1 << size) - 4'd1;
    assign misalign     = |(va[2:0] & size_mask[2:0]);
    assign top_bits     = va_eff[VA_W-1 -: TOP_W];
    assign out_of_range = (|top_bits) && !(&top_bits);

    assign ctx  = (ctrl[TL_LSB +: TL_W] != '0) ? '0 : ctrl[PCTX_LSB +: CTX_W];
    assign part = ctrl[PART_LSB +: PART_W];

endmodule

// File: rtl/xac_check.sv
module xac_check
    import xac_pkg::*;
(
    input  xmode_e mode,
    input  logic   is_fetch,
    input  logic   write,
    input  logic   misalign,
    input  logic   out_of_range,
    input  logic   user_mode,
    input  logic   hit,
    input  logic   pg_writable,
    input  logic   pg_nofault,
    input  logic   pg_sidefx,
    input  logic   pg_priv,
    output fault_e fault,
    output logic   lookup,
    output logic   uncache
);
    // Fixed-priority fault chain
    always_comb begin
        fault = FLT_NONE;
        if (mode == MODE_BYPASS)
            fault = FLT_NONE;
        else if (misalign)
            fault = FLT_ALIGN;
        else if (out_of_range)
            fault = FLT_RANGE;
        else if (!hit)
            fault = (mode == MODE_REAL) ? FLT_RMISS : FLT_MISS;
        else if (!is_fetch && write && !pg_writable)
            fault = FLT_PROT;
        else if (!is_fetch && pg_nofault)
            fault = FLT_NOFLT;
        else if (user_mode && pg_priv)
            fault = FLT_PRIV;
    end

    assign lookup  = (mode != MODE_BYPASS) && !misalign && !out_of_range;
    assign uncache = lookup && hit && pg_sidefx && (fault == FLT_NONE);

endmodule

// File: rtl/xlat_access_checker.sv
module xlat_access_checker
    import xac_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PA_W      = 40,
    parameter int IMPL_VA_W = 48,
    parameter int PAGE_SH   = 13,
    parameter int CTX_W     = 13,
    localparam int PAGE_W   = VA_W - PAGE_SH,
    localparam int PPN_W    = PA_W - PAGE_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_fetch,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [VA_W-1:0]   req_va,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              lkp_en,
    output logic              lkp_real,
    output logic [PAGE_W-1:0] lkp_page,
    output logic [CTX_W-1:0]  lkp_ctx,
    output logic [PART_W-1:0] lkp_part,
    input  logic              tlb_hit,
    input  logic [PPN_W-1:0]  tlb_ppn,
    input  logic              tlb_writable,
    input  logic              tlb_nofault,
    input  logic              tlb_sidefx,
    input  logic              tlb_priv,
    output logic              rsp_valid,
    output logic [2:0]        rsp_fault,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_uncache,
    output logic [2:0]        fsr_q,
    output logic [VA_W-1:0]   far_q,
    output logic [VA_W-1:0]   tag_q
);
    state_e state_q, state_d;

    xmode_e            mode;
    fault_e            fault;
    logic [VA_W-1:0]   va_eff;
    logic              misalign, out_of_range, user_mode, lookup, uncache;
    logic [CTX_W-1:0]  ctx;
    logic [PA_W-1:0]   pa_d;
    logic              is_miss;

    xac_decode #(
        .VA_W(VA_W), .IMPL_VA_W(IMPL_VA_W), .CTX_W(CTX_W)
    ) u_decode (
        .ctrl(ctrl_word), .is_fetch(req_fetch), .size(req_size), .va(req_va),
        .mode(mode), .va_eff(va_eff), .misalign(misalign),
        .out_of_range(out_of_range), .user_mode(user_mode),
        .ctx(ctx), .part(lkp_part)
    );

    xac_check u_check (
        .mode(mode), .is_fetch(req_fetch), .write(req_write),
        .misalign(misalign), .out_of_range(out_of_range),
        .user_mode(user_mode), .hit(tlb_hit),
        .pg_writable(tlb_writable), .pg_nofault(tlb_nofault),
        .pg_sidefx(tlb_sidefx), .pg_priv(tlb_priv),
        .fault(fault), .lookup(lookup), .uncache(uncache)
    );

    assign lkp_en   = req_valid && lookup;
    assign lkp_real = (mode == MODE_REAL);
    assign lkp_page = va_eff[VA_W-1:PAGE_SH];
    assign lkp_ctx  = ctx;
    assign is_miss  = (fault == FLT_MISS) || (fault == FLT_RMISS);

    always_comb begin
        if (fault != FLT_NONE)
            pa_d = '0;
        else if (mode == MODE_BYPASS)
            pa_d = req_va[PA_W-1:0];
        else
            pa_d = {tlb_ppn, va_eff[PAGE_SH-1:0]};
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept, chain, drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid) state_d = S_RESP;
            S_RESP: state_d = req_valid ? S_RESP : S_IDLE;
        endcase
    end

    // Outputs
    assign rsp_valid = (state_q == S_RESP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_fault   <= '0;
            rsp_pa      <= '0;
            rsp_uncache <= 1'b0;
            fsr_q       <= '0;
            far_q       <= '0;
            tag_q       <= '0;
        end else if (req_valid) begin
            rsp_fault   <= fault;
            rsp_pa      <= pa_d;
            rsp_uncache <= uncache;
            if (fault != FLT_NONE) begin
                fsr_q <= fault;
                if (!req_fetch) far_q <= va_eff;
            end
            if (is_miss)
                tag_q <= {va_eff[VA_W-1:PAGE_SH], PAGE_SH'(ctx)};
        end
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R10
    fsr_tracks_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> (fsr_q == rsp_fault));
    // R9
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> (rsp_pa == '0 && !rsp_uncache));
    // R11
    far_fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fetch) |=> $stable(far_q));
    // R12
    tag_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(tag_q));

endmodule

// File: tb/xlat_access_checker_tb.sv
module xlat_access_checker_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        fetch;
        logic        wr;
        logic [1:0]  sz;
        logic [63:0] va;
        logic [47:0] cw;
        logic        hit;
        logic [26:0] ppn;
        logic        tw;
        logic        tnf;
        logic        tse;
        logic        tpr;
        logic [2:0]  ef;
        logic [39:0] epa;
        logic        eunc;
        logic        elkp;
        logic        ereal;
        logic [12:0] ectx;
    } vec_t;

    localparam logic [47:0] CW_HP   = 48'h0000_0000_0001;
    localparam logic [47:0] CW_RED  = 48'h0000_0000_0002;
    localparam logic [47:0] CW_VIRT = 48'h0123_0000_0534;
    localparam logic [47:0] CW_USER = 48'h0123_0000_0530;
    localparam logic [47:0] CW_REAL = 48'h0123_0000_0504;
    localparam logic [47:0] CW_TL   = 48'h0123_0002_0534;
    localparam logic [47:0] CW_AM   = 48'h0123_0000_053C;
    localparam logic [63:0] VA_A    = 64'h0000_0000_1234_5678;
    localparam logic [26:0] PPN     = 27'h0000ABC;
    localparam logic [39:0] PA_A    = 40'h00_0157_9678;

    localparam int NV = 22;
    localparam vec_t VT [NV] = '{
        '{1'b1,1'b0,2'd2,64'hFFFF_0000_1234_5678,CW_HP,1'b0,PPN,1'b1,1'b0,1'b0,1'b0,3'd0,40'h00_1234_5678,1'b0,1'b0,1'b0,13'h0},
        '{1'b1,1'b0,2'd2,64'hFFFF_0000_1234_5678,CW_RED,1'b0,PPN,1'b1,1'b0,1'b0,1'b0,3'd0,40'h00_1234_5678,1'b0,1'b0,1'b0,13'h0},
        '{1'b0,1'b0,2'd3,VA_A,CW_RED,1'b1,PPN,1'b1,1'b0,1'b0,1'b0,3'd0,PA_A,1'b0,1'b1,1'b0,13'h0},
        '{1'b0,1'b0,2'd3,64'h1234_5679,CW_HP,1'b0,PPN,1'b1,1'b0,1'b0,1'b0,3'd0,40'h00_1234_5679,1'b0,1'b0,1'b0,13'h0},
        '{1'b0,1'b0,2'd1,64'h1234_5679,CW_VIRT,1'b1,PPN,1'b1,1'b0,1'b0,1'b0,3'd1,40'h0,1'b0,1'b0,1'b0,13'h123},
        '{1'b0,1'b0,2'd2,64'h8000_0000_0000_0001,CW_VIRT,1'b1,PPN,1'b1,1'b0,1'b0,1'b0,3'd1,40'h0,1'b0,1'b0,1'b0,13'h123},
        '{1'b0,1'b0,2'd3,64'h0001_0000_0000_0000,CW_VIRT,1'b1,PPN,1'b1,1'b0,1'b0,1'b0,3'd2,40'h0,1'b0,1'b0,1'b0,13'h123},
        '{1'b0,1'b0,2'd3,64'h0001_0000_0000_0000,CW_AM,1'b1,PPN,1'b1,1'b0,1'b0,1'b0,3'd0,40'h00_0157_8000,1'b0,1'b1,1'b0,13'h123},
        '{1'b0,1'b0,2'd3,64'hFFFF_8000_0000_0000,CW_VIRT,1'b1,PPN,1'b1,1'b0,1'b0,1'b0,3'd0,40'h00_0157_8000,1'b0,1'b1,1'b0,13'h123},
        '{1'b0,1'b0,2'd3,VA_A,CW_VIRT,1'b0,PPN,1'b1,1'b0,1'b0,1'b0,3'd3,40'h0,1'b0,1'b1,1'b0,13'h123},
        '{1'b0,1'b0,2'd3,VA_A,CW_REAL,1'b0,PPN,1'b1,1'b0,1'b0,1'b0,3'd7,40'h0,1'b0,1'b1,1'b1,13'h123},
        '{1'b0,1'b1,2'd3,VA_A,CW_USER,1'b1,PPN,1'b0,1'b1,1'b0,1'b1,3'd4,40'h0,1'b0,1'b1,1'b0,13'h123},
        '{1'b0,1'b0,2'd3,VA_A,CW_USER,1'b1,PPN,1'b1,1'b1,1'b0,1'b1,3'd5,40'h0,1'b0,1'b1,1'b0,13'h123},
        '{1'b0,1'b0,2'd3,VA_A,CW_USER,1'b1,PPN,1'b1,1'b0,1'b0,1'b1,3'd6,40'h0,1'b0,1'b1,1'b0,13'h123},
        '{1'b0,1'b0,2'd3,VA_A,CW_VIRT,1'b1,PPN,1'b0,1'b0,1'b0,1'b1,3'd0,PA_A,1'b0,1'b1,1'b0,13'h123},
        '{1'b0,1'b1,2'd3,VA_A,CW_USER,1'b1,PPN,1'b1,1'b0,1'b1,1'b0,3'd0,PA_A,1'b1,1'b1,1'b0,13'h123},
        '{1'b0,1'b0,2'd3,VA_A,CW_USER,1'b1,PPN,1'b1,1'b0,1'b1,1'b1,3'd6,40'h0,1'b0,1'b1,1'b0,13'h123},
        '{1'b1,1'b1,2'd2,VA_A,CW_USER,1'b1,PPN,1'b0,1'b1,1'b0,1'b0,3'd0,PA_A,1'b0,1'b1,1'b0,13'h123},
        '{1'b1,1'b0,2'd2,VA_A,CW_REAL,1'b0,PPN,1'b1,1'b0,1'b0,1'b0,3'd7,40'h0,1'b0,1'b1,1'b1,13'h123},
        '{1'b1,1'b0,2'd2,VA_A,CW_USER,1'b1,PPN,1'b1,1'b0,1'b0,1'b1,3'd6,40'h0,1'b0,1'b1,1'b0,13'h123},
        '{1'b0,1'b0,2'd3,VA_A,CW_TL,1'b0,PPN,1'b1,1'b0,1'b0,1'b0,3'd3,40'h0,1'b0,1'b1,1'b0,13'h0},
        '{1'b1,1'b0,2'd2,64'h1234_5676,CW_VIRT,1'b1,PPN,1'b1,1'b0,1'b0,1'b0,3'd1,40'h0,1'b0,1'b0,1'b0,13'h123}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_fetch = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_va = '0;
    logic [47:0] ctrl_word = '0;
    logic        tlb_hit = 1'b0, tlb_writable = 1'b0, tlb_nofault = 1'b0;
    logic        tlb_sidefx = 1'b0, tlb_priv = 1'b0;
    logic [26:0] tlb_ppn = '0;
    logic        lkp_en, lkp_real, rsp_valid, rsp_uncache;
    logic [50:0] lkp_page;
    logic [12:0] lkp_ctx;
    logic [7:0]  lkp_part;
    logic [2:0]  rsp_fault, fsr_q;
    logic [39:0] rsp_pa;
    logic [63:0] far_q, tag_q;

    int n_chk = 0;
    int n_fail = 0;
    logic [2:0]  m_fsr = '0;
    logic [63:0] m_far = '0, m_tag = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_access_checker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fetch(req_fetch),
        .req_write(req_write), .req_size(req_size), .req_va(req_va),
        .ctrl_word(ctrl_word), .lkp_en(lkp_en), .lkp_real(lkp_real),
        .lkp_page(lkp_page), .lkp_ctx(lkp_ctx), .lkp_part(lkp_part),
        .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_writable(tlb_writable),
        .tlb_nofault(tlb_nofault), .tlb_sidefx(tlb_sidefx), .tlb_priv(tlb_priv),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
        .rsp_uncache(rsp_uncache), .fsr_q(fsr_q), .far_q(far_q), .tag_q(tag_q)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid    = 1'b1;
        req_fetch    = v.fetch;
        req_write    = v.wr;
        req_size     = v.sz;
        req_va       = v.va;
        ctrl_word    = v.cw;
        tlb_hit      = v.hit;
        tlb_ppn      = v.ppn;
        tlb_writable = v.tw;
        tlb_nofault  = v.tnf;
        tlb_sidefx   = v.tse;
        tlb_priv     = v.tpr;
    endtask

    // Model update of the status registers from the requirements
    task automatic model(input vec_t v);
        logic [63:0] mva;
        mva = v.cw[3] ? {32'h0, v.va[31:0]} : v.va;
        if (v.ef != 3'd0) begin
            m_fsr = v.ef;                         // R10
            if (!v.fetch) m_far = mva;            // R11
        end
        if (v.ef == 3'd3 || v.ef == 3'd7)
            m_tag = {mva[63:13], v.ectx};         // R7
    endtask

    task automatic check_lookup(input vec_t v, input int idx);
        logic [63:0] mva;
        mva = v.cw[3] ? {32'h0, v.va[31:0]} : v.va;
        chk(lkp_en == v.elkp, "R3/R4/R5", $sformatf("lkp_en vec %0d", idx), 64'(lkp_en), 64'(v.elkp));
        if (v.elkp) begin
            chk(lkp_real == v.ereal, "R6", $sformatf("lkp_real vec %0d", idx), 64'(lkp_real), 64'(v.ereal));
            chk(lkp_ctx == v.ectx, "R6", $sformatf("lkp_ctx vec %0d", idx), 64'(lkp_ctx), 64'(v.ectx));
            chk(lkp_part == v.cw[15:8], "R6", $sformatf("lkp_part vec %0d", idx), 64'(lkp_part), 64'(v.cw[15:8]));
            chk(lkp_page == mva[63:13], "R5", $sformatf("lkp_page vec %0d", idx), 64'(lkp_page), 64'(mva[63:13]));
        end
    endtask

    task automatic check_rsp(input vec_t v, input int idx);
        chk(rsp_valid == 1'b1, "R2", $sformatf("rsp_valid vec %0d", idx), 64'(rsp_valid), 64'd1);
        chk(rsp_fault == v.ef, "R8", $sformatf("fault vec %0d", idx), 64'(rsp_fault), 64'(v.ef));
        chk(rsp_pa == v.epa, "R9", $sformatf("pa vec %0d", idx), 64'(rsp_pa), 64'(v.epa));
        chk(rsp_uncache == v.eunc, "R9", $sformatf("uncache vec %0d", idx), 64'(rsp_uncache), 64'(v.eunc));
        chk(fsr_q == m_fsr, "R10", $sformatf("fsr vec %0d", idx), 64'(fsr_q), 64'(m_fsr));
        chk(far_q == m_far, "R11", $sformatf("far vec %0d", idx), far_q, m_far);
        chk(tag_q == m_tag, "R7 R12", $sformatf("tag vec %0d", idx), tag_q, m_tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk(fsr_q == 3'd0, "R1", "fsr after reset", 64'(fsr_q), 64'd0);
        chk(far_q == 64'd0, "R1", "far after reset", far_q, 64'd0);
        chk(tag_q == 64'd0, "R1", "tag after reset", tag_q, 64'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(VT[i]);
            #1;
            check_lookup(VT[i], i);
            model(VT[i]);
            @(negedge clk);
            req_valid = 1'b0;
            check_rsp(VT[i], i);
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R2", $sformatf("rsp_valid drop vec %0d", i), 64'(rsp_valid), 64'd0);
        end

        // R2 R12: idle cycles leave everything still
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R2", "idle rsp_valid", 64'(rsp_valid), 64'd0);
        chk(tag_q == m_tag, "R12", "idle tag", tag_q, m_tag);
        chk(fsr_q == m_fsr, "R10", "idle fsr", 64'(fsr_q), 64'(m_fsr));

        // Back-to-back: miss then clean hit (chain transition)
        drive(VT[9]);
        model(VT[9]);
        @(negedge clk);
        check_rsp(VT[9], 9);
        drive(VT[14]);
        model(VT[14]);
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(VT[14], 14);   // R12: tag held by the hit, R10: fsr held
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2", "drain after chain", 64'(rsp_valid), 64'd0);

        // R11: a fetch fault after a data fault leaves far alone
        drive(VT[21]);
        model(VT[21]);
        @(negedge clk);
        req_valid = 1'b0;
        chk(far_q == m_far, "R11", "far after fetch fault", far_q, m_far);
        chk(fsr_q == 3'd1, "R10", "fsr after fetch fault", 64'(fsr_q), 64'd1);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule